// File: doc/BRIEF.md
# Configurable-Frame Serial Peripheral Master

This block is a synchronous serial master for talking to external peripherals over SPI. It generates the serial clock from the system clock with a programmable divider. It shifts one frame at a time, and a frame can be anywhere from 4 to 16 bits long. Each serial clock cycle moves one bit out on the data-out line and takes one bit in from the data-in line. All four combinations of idle clock level and sampling phase are available, and the bit order can be most-significant first or least-significant first.

Outgoing words are queued in a transmit FIFO and incoming frames collect in a receive FIFO. A frame starts as soon as a word is waiting and the receive FIFO has a free entry. The select line can be handled in either of two ways:
- The block wraps each frame with it automatically.
- Software drives it from a configuration bit and can hold it across several frames.

Two level flags report that the transmit side has room and that the receive side holds data. Each flag can be routed to an interrupt line through its own enable.

Top module: `spi_frame_master`

## Requirements
- R1: While reset is applied and after reset is released, cs_n is high, busy is low, tx_room is 1 and rx_avail is 0. During reset, sclk is 0.
- R2: While idle, sclk rests at cfg_cpol. During a frame, sclk changes level every cfg_prescale+1 system clock cycles, so a value of 0 gives the system clock divided by 2.
- R3: A frame with cfg_frame_len = N (4 to 16) produces exactly 2N sclk edges. After the last of them, sclk is back at its idle level.
- R4: When cfg_cpha is 0, miso is sampled on the edge that leaves the idle level and mosi changes on the edge that returns to it. When cfg_cpha is 1, mosi changes on the leaving edge and miso is sampled on the returning edge.
- R5: When cfg_lsb_first is 0, tx_data[N-1] is sent first and tx_data[0] is sent last. When cfg_lsb_first is 1, tx_data[0] is sent first. Bits of tx_data at position N and above have no effect.
- R6: A received frame is right-aligned in the 16-bit rx_data, and bits N to 15 are 0. The first bit received goes to position N-1 when cfg_lsb_first is 0, and to position 0 when it is 1.
- R7: In automatic select mode (cfg_sw_cs = 0), cs_n goes low cfg_prescale+1 cycles before the first sclk edge of a frame. It goes high again cfg_prescale+1 cycles after the last edge.
- R8: In software select mode (cfg_sw_cs = 1), cs_n equals the inverse of cfg_sw_sel at all times, whether or not a frame is running.
- R9: No frame starts, and busy stays low, while the transmit FIFO is empty or the receive FIFO is full. A pending word starts as soon as the blocking condition clears.
- R10: tx_room is 1 exactly when the transmit FIFO is not full, and rx_avail is 1 exactly when the receive FIFO is not empty. irq_tx equals tx_room AND cfg_tx_ie, and irq_rx equals rx_avail AND cfg_rx_ie.
- R11: Frames are sent in the order the words were written, and received frames are read out in the order they arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_prescale | input | PRE_W | Half-period of sclk minus one, in system cycles |
| cfg_cpol | input | 1 | Idle level of sclk |
| cfg_cpha | input | 1 | Sampling phase (0: sample on leaving edge) |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_frame_len | input | clog2(MAX_BITS+1) | Bits per frame, 4 to 16 |
| cfg_sw_cs | input | 1 | 1: select line under software control |
| cfg_sw_sel | input | 1 | Software select request (1 asserts cs_n low) |
| cfg_tx_ie | input | 1 | Enable for irq_tx |
| cfg_rx_ie | input | 1 | Enable for irq_rx |
| tx_wr | input | 1 | Push tx_data into the transmit FIFO |
| tx_data | input | MAX_BITS | Word to send, right-aligned |
| tx_room | output | 1 | Transmit FIFO not full |
| rx_rd | input | 1 | Pop the head of the receive FIFO |
| rx_data | output | MAX_BITS | Head of the receive FIFO |
| rx_avail | output | 1 | Receive FIFO not empty |
| irq_tx | output | 1 | Transmit room interrupt |
| irq_rx | output | 1 | Receive data interrupt |
| busy | output | 1 | Frame in progress |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low select |

## Verification
The bench builds the block with PRE_W = 4 and FIFO_DEPTH = 4, and keeps 16-bit frames. The shallow FIFOs mean a few writes are enough to fill both queues. That makes it quick to reach the stalled-start condition, the full transmit flag and in-order draining. The narrow divider still allows half-periods of 1, 3 and 4 cycles, so edge spacing and select lead and lag can be measured at both the fastest rate and slower ones. A slave model follows all four clock modes, and a loopback path checks ordering with distinct words.

// File: rtl/spim_pkg.sv
package spim_pkg;

  localparam int unsigned SPIM_MIN_BITS = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_TRAIL = 2'd2
  } spim_state_e;

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] pop_data,
  output logic             full,
  output logic             empty
);

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= push_data;
  end

  assign pop_data = mem_q[rd_q];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (cnt_q == CW'(DEPTH))); // R10
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (cnt_q == '0)); // R10

endmodule

// File: rtl/spim_engine.sv
module spim_engine
  import spim_pkg::*;
#(
  parameter int unsigned PRE_W    = 8,
  parameter int unsigned MAX_BITS = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [PRE_W-1:0]              cfg_prescale,
  input  logic                          cfg_cpol,
  input  logic                          cfg_cpha,
  input  logic                          cfg_lsb_first,
  input  logic [$clog2(MAX_BITS+1)-1:0] cfg_frame_len,
  input  logic                          start_ok,
  input  logic [MAX_BITS-1:0]           tx_word,
  output logic                          tx_pop,
  output logic [MAX_BITS-1:0]           rx_word,
  output logic                          rx_push,
  output logic                          sclk,
  output logic                          mosi,
  input  logic                          miso,
  output logic                          frame_active
);

  localparam int unsigned LW = $clog2(MAX_BITS + 1);
  localparam int unsigned EW = LW + 1;
  localparam int unsigned IW = $clog2(MAX_BITS);

  spim_state_e         state_q, state_d;
  logic [PRE_W-1:0]    hcnt_q, hcnt_d, pre_q, pre_d;
  logic [EW-1:0]       ecnt_q, ecnt_d;
  logic [LW-1:0]       len_q, len_d;
  logic                cpha_q, cpha_d, cpol_q, cpol_d, lsb_q, lsb_d;
  logic                sclk_q, sclk_d;
  logic [MAX_BITS-1:0] txf_q, txf_d, rxf_q, rxf_d;

  logic                tick, last_edge, sample_edge;
  logic [EW-1:0]       out_cnt;
  logic [LW-1:0]       out_idx, smp_idx, out_full, smp_full;
  logic [IW-1:0]       out_pos, smp_pos;

  assign tick        = (hcnt_q == pre_q);
  assign last_edge   = (ecnt_q == (EW'(len_q) << 1) - 1'b1);
  assign sample_edge = (ecnt_q[0] == cpha_q);

  // bit index on the line: with late phase, the first leaving edge launches bit 0
  always_comb begin
    out_cnt = (cpha_q && ecnt_q != '0) ? ecnt_q - 1'b1 : ecnt_q;
    out_idx = LW'(out_cnt >> 1);
    if (out_idx >= len_q) out_idx = len_q - 1'b1;
    smp_idx  = LW'(ecnt_q >> 1);
    out_full = lsb_q ? out_idx : len_q - 1'b1 - out_idx;
    smp_full = lsb_q ? smp_idx : len_q - 1'b1 - smp_idx;
    out_pos  = IW'(out_full);
    smp_pos  = IW'(smp_full);
  end

  always_comb begin
    state_d = state_q;
    hcnt_d  = hcnt_q;
    pre_d   = pre_q;
    ecnt_d  = ecnt_q;
    len_d   = len_q;
    cpha_d  = cpha_q;
    cpol_d  = cpol_q;
    lsb_d   = lsb_q;
    sclk_d  = sclk_q;
    txf_d   = txf_q;
    rxf_d   = rxf_q;
    tx_pop  = 1'b0;
    rx_push = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        sclk_d = cfg_cpol;
        hcnt_d = '0;
        if (start_ok) begin
          state_d = ST_SHIFT;
          tx_pop  = 1'b1;
          txf_d   = tx_word;
          rxf_d   = '0;
          ecnt_d  = '0;
          pre_d   = cfg_prescale;
          cpha_d  = cfg_cpha;
          cpol_d  = cfg_cpol;
          lsb_d   = cfg_lsb_first;
          if (cfg_frame_len < LW'(SPIM_MIN_BITS))  len_d = LW'(SPIM_MIN_BITS);
          else if (cfg_frame_len > LW'(MAX_BITS))  len_d = LW'(MAX_BITS);
          else                                     len_d = cfg_frame_len;
        end
      end
      ST_SHIFT: begin
        if (tick) begin
          hcnt_d = '0;
          sclk_d = ~sclk_q;
          ecnt_d = ecnt_q + 1'b1;
          if (sample_edge) rxf_d[smp_pos] = miso;
          if (last_edge) state_d = ST_TRAIL;
        end else begin
          hcnt_d = hcnt_q + 1'b1;
        end
      end
      ST_TRAIL: begin
        if (tick) begin
          hcnt_d  = '0;
          state_d = ST_IDLE;
          rx_push = 1'b1;
        end else begin
          hcnt_d = hcnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hcnt_q  <= '0;
      pre_q   <= '0;
      ecnt_q  <= '0;
      len_q   <= LW'(SPIM_MIN_BITS);
      cpha_q  <= 1'b0;
      cpol_q  <= 1'b0;
      lsb_q   <= 1'b0;
      sclk_q  <= 1'b0;
      txf_q   <= '0;
      rxf_q   <= '0;
    end else begin
      state_q <= state_d;
      hcnt_q  <= hcnt_d;
      pre_q   <= pre_d;
      ecnt_q  <= ecnt_d;
      len_q   <= len_d;
      cpha_q  <= cpha_d;
      cpol_q  <= cpol_d;
      lsb_q   <= lsb_d;
      sclk_q  <= sclk_d;
      txf_q   <= txf_d;
      rxf_q   <= rxf_d;
    end
  end

  assign sclk         = sclk_q;
  assign mosi         = txf_q[out_pos];
  assign rx_word      = rxf_q;
  assign frame_active = (state_q != ST_IDLE);

  AST_EDGE_PACE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_SHIFT && sclk_q != $past(sclk_q)) |-> $past(tick)); // R2
  AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TRAIL) |-> (sclk_q == cpol_q)); // R3
  AST_RX_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> ((rxf_q >> len_q) == '0)); // R6

endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master #(
  parameter int unsigned PRE_W      = 8,
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned MAX_BITS   = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [PRE_W-1:0]              cfg_prescale,
  input  logic                          cfg_cpol,
  input  logic                          cfg_cpha,
  input  logic                          cfg_lsb_first,
  input  logic [$clog2(MAX_BITS+1)-1:0] cfg_frame_len,
  input  logic                          cfg_sw_cs,
  input  logic                          cfg_sw_sel,
  input  logic                          cfg_tx_ie,
  input  logic                          cfg_rx_ie,
  input  logic                          tx_wr,
  input  logic [MAX_BITS-1:0]           tx_data,
  output logic                          tx_room,
  input  logic                          rx_rd,
  output logic [MAX_BITS-1:0]           rx_data,
  output logic                          rx_avail,
  output logic                          irq_tx,
  output logic                          irq_rx,
  output logic                          busy,
  output logic                          sclk,
  output logic                          mosi,
  input  logic                          miso,
  output logic                          cs_n
);

  logic [1:0]          rst_pipe_q;
  logic                rst_s_n;
  logic                tx_full, tx_empty, rx_full, rx_empty;
  logic                tx_pop, rx_push, start_ok, frame_active;
  logic [MAX_BITS-1:0] tx_head, rx_word;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[1];

  spim_fifo #(.WIDTH(MAX_BITS), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_s_n),
    .push(tx_wr), .push_data(tx_data),
    .pop(tx_pop), .pop_data(tx_head),
    .full(tx_full), .empty(tx_empty)
  );

  spim_fifo #(.WIDTH(MAX_BITS), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_s_n),
    .push(rx_push), .push_data(rx_word),
    .pop(rx_rd), .pop_data(rx_data),
    .full(rx_full), .empty(rx_empty)
  );

  assign start_ok = ~tx_empty & ~rx_full;

  spim_engine #(.PRE_W(PRE_W), .MAX_BITS(MAX_BITS)) u_engine (
    .clk(clk), .rst_n(rst_s_n),
    .cfg_prescale(cfg_prescale), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_lsb_first(cfg_lsb_first), .cfg_frame_len(cfg_frame_len),
    .start_ok(start_ok), .tx_word(tx_head), .tx_pop(tx_pop),
    .rx_word(rx_word), .rx_push(rx_push),
    .sclk(sclk), .mosi(mosi), .miso(miso), .frame_active(frame_active)
  );

  assign busy     = frame_active;
  assign tx_room  = ~tx_full;
  assign rx_avail = ~rx_empty;
  assign irq_tx   = tx_room & cfg_tx_ie;
  assign irq_rx   = rx_avail & cfg_rx_ie;
  assign cs_n     = cfg_sw_cs ? ~cfg_sw_sel : ~frame_active;

  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(busy) |-> $past(!tx_empty && !rx_full)); // R9
  AST_PUSH_HAS_SPACE: assert property (@(posedge clk) disable iff (!rst_s_n)
    rx_push |-> !rx_full); // R9

endmodule

// File: tb/spi_frame_master_bench.sv
`timescale 1ns/1ps
module spi_frame_master_bench;

  localparam int unsigned PRE_W = 4;
  localparam int unsigned DEPTH = 4;
  localparam int unsigned MAXB  = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic [PRE_W-1:0] cfg_prescale;
  logic cfg_cpol, cfg_cpha, cfg_lsb_first, cfg_sw_cs, cfg_sw_sel, cfg_tx_ie, cfg_rx_ie;
  logic [4:0] cfg_frame_len;
  logic tx_wr, rx_rd, miso;
  logic [MAXB-1:0] tx_data, rx_data;
  logic tx_room, rx_avail, irq_tx, irq_rx, busy, sclk, mosi, cs_n;

  int n_checks = 0;
  int n_errors = 0;

  // slave model state
  logic        loopback;
  logic [15:0] slv_out_seq, slv_in_seq;
  int          slv_cnt;
  logic        slv_miso;

  always #2.5 clk = ~clk;

  assign miso = loopback ? mosi : slv_miso;

  spi_frame_master #(.PRE_W(PRE_W), .FIFO_DEPTH(DEPTH), .MAX_BITS(MAXB)) u_spi_frame_master (
    .clk(clk), .rst_n(rst_n),
    .cfg_prescale(cfg_prescale), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_lsb_first(cfg_lsb_first), .cfg_frame_len(cfg_frame_len),
    .cfg_sw_cs(cfg_sw_cs), .cfg_sw_sel(cfg_sw_sel),
    .cfg_tx_ie(cfg_tx_ie), .cfg_rx_ie(cfg_rx_ie),
    .tx_wr(tx_wr), .tx_data(tx_data), .tx_room(tx_room),
    .rx_rd(rx_rd), .rx_data(rx_data), .rx_avail(rx_avail),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .busy(busy),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  // slave: on each sample edge capture mosi, then present the next bit
  always @(sclk) begin
    if (cs_n === 1'b0 && ((sclk !== cfg_cpol) ^ cfg_cpha)) begin
      #1;
      if (slv_cnt < 16) slv_in_seq[slv_cnt] = mosi;
      slv_cnt = slv_cnt + 1;
      slv_miso = slv_out_seq[(slv_cnt < 16) ? slv_cnt : 15];
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] to_seq(input logic [15:0] w, input int len, input logic lsb);
    logic [15:0] s = '0;
    for (int i = 0; i < len; i++) s[i] = lsb ? w[i] : w[len-1-i];
    return s;
  endfunction

  function automatic logic [15:0] from_seq(input logic [15:0] s, input int len, input logic lsb);
    logic [15:0] w = '0;
    for (int i = 0; i < len; i++) begin
      if (lsb) w[i] = s[i];
      else     w[len-1-i] = s[i];
    end
    return w;
  endfunction

  function automatic logic [15:0] lowmask(input int len);
    return 16'((32'h1 << len) - 1);
  endfunction

  task automatic push_tx(input logic [15:0] w);
    @(negedge clk); tx_data = w; tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic pop_rx();
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic wait_idle_rx();
    int guard = 0;
    while (!(rx_avail && !busy) && guard < 5000) begin @(negedge clk); guard++; end
  endtask

  task automatic slave_prep(input logic [15:0] w, input int len, input logic lsb);
    slv_out_seq = to_seq(w, len, lsb);
    slv_in_seq  = '0;
    slv_cnt     = 0;
    slv_miso    = slv_out_seq[0];
  endtask

  // R4 R5 R6: one frame through the slave model in a given mode
  task automatic t_frame(input logic cpol, input logic cpha, input logic lsb, input int len,
                         input int pre, input logic [15:0] txw, input logic [15:0] slvw);
    @(negedge clk);
    cfg_cpol = cpol; cfg_cpha = cpha; cfg_lsb_first = lsb;
    cfg_frame_len = 5'(len); cfg_prescale = PRE_W'(pre); loopback = 1'b0;
    repeat (2) @(negedge clk);
    slave_prep(slvw, len, lsb);
    push_tx(txw);
    wait_idle_rx();
    chk("R5 mosi word seen by slave", 32'(from_seq(slv_in_seq, len, lsb)), 32'(txw & lowmask(len)));
    chk("R6 received word aligned", 32'(rx_data), 32'(slvw & lowmask(len)));
    chk("R4 slave sample count", 32'(slv_cnt), 32'(len));
    chk("R2 sclk parked at cpol", 32'(sclk), 32'(cpol));
    pop_rx();
  endtask

  // R2 R3 R7: edge spacing, edge count, select lead and lag
  task automatic t_timing(input int pre, input int len);
    int cyc = 0, t_fall = -1, t_first = -1, t_last = -1, t_rise = -1, n_edges = 0, bad_gap = 0;
    logic prev_s, prev_cs;
    @(negedge clk);
    cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_lsb_first = 1'b0;
    cfg_frame_len = 5'(len); cfg_prescale = PRE_W'(pre); loopback = 1'b1;
    push_tx(16'h0005);
    prev_s = sclk; prev_cs = cs_n;
    while (t_rise < 0 && cyc < 3000) begin
      @(negedge clk); cyc++;
      if (prev_cs && !cs_n) t_fall = cyc;
      if (sclk !== prev_s) begin
        if (n_edges == 0) t_first = cyc;
        else if (cyc - t_last != pre + 1) bad_gap++;
        t_last = cyc; n_edges++;
      end
      if (!prev_cs && cs_n) t_rise = cyc;
      prev_s = sclk; prev_cs = cs_n;
    end
    chk("R2 uneven sclk half periods", 32'(bad_gap), 32'd0);
    chk("R3 sclk edges per frame", 32'(n_edges), 32'(2 * len));
    chk("R7 select lead cycles", 32'(t_first - t_fall), 32'(pre + 1));
    chk("R7 select lag cycles", 32'(t_rise - t_last), 32'(pre + 1));
    wait_idle_rx();
    pop_rx();
  endtask

  // R8: software-held select
  task automatic t_sw_select();
    int drops = 0;
    @(negedge clk);
    cfg_sw_cs = 1'b1; cfg_sw_sel = 1'b0;
    @(negedge clk);
    chk("R8 select released by software", 32'(cs_n), 32'd1);
    cfg_sw_sel = 1'b1;
    @(negedge clk);
    chk("R8 select held while idle", 32'(cs_n), 32'd0);
    cfg_cpol = 1'b0; cfg_cpha = 1'b1; cfg_lsb_first = 1'b0;
    cfg_frame_len = 5'd8; cfg_prescale = PRE_W'(1); loopback = 1'b0;
    slave_prep(16'h00C3, 8, 1'b0);
    push_tx(16'h005A);
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (cs_n !== 1'b0) drops++;
    end
    chk("R8 select stays low across frame", 32'(drops), 32'd0);
    chk("R8 frame data under software select", 32'(rx_data), 32'h00C3);
    chk("R5 mosi under software select", 32'(from_seq(slv_in_seq, 8, 1'b0)), 32'h005A);
    pop_rx();
    @(negedge clk); cfg_sw_sel = 1'b0;
    @(negedge clk);
    chk("R8 select follows bit off", 32'(cs_n), 32'd1);
    cfg_sw_cs = 1'b0;
  endtask

  // R9 R10 R11: stalls on full receive queue, full transmit flag, ordering
  task automatic t_gating_order();
    int started = 0;
    logic [15:0] expw;
    @(negedge clk);
    cfg_cpol = 1'b1; cfg_cpha = 1'b1; cfg_lsb_first = 1'b1;
    cfg_frame_len = 5'd8; cfg_prescale = PRE_W'(0); loopback = 1'b1;
    cfg_tx_ie = 1'b1; cfg_rx_ie = 1'b1;
    for (int i = 1; i <= 4; i++) push_tx(16'(i * 16'h11));
    repeat (120) @(negedge clk);
    chk("R10 irq_rx with data", 32'(irq_rx), 32'd1);
    for (int i = 5; i <= 8; i++) push_tx(16'(i * 16'h11));
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (busy) started++;
    end
    chk("R9 no frame with receive queue full", 32'(started), 32'd0);
    chk("R10 tx_room low when full", 32'(tx_room), 32'd0);
    chk("R10 irq_tx low when full", 32'(irq_tx), 32'd0);
    for (int i = 1; i <= 8; i++) begin
      expw = 16'(i * 16'h11);
      chk("R11 receive order", 32'(rx_data), 32'(expw));
      pop_rx();
      repeat (40) @(negedge clk);
    end
    chk("R9 pending words drained", 32'(rx_avail), 32'd0);
    chk("R10 tx_room after drain", 32'(tx_room), 32'd1);
    cfg_rx_ie = 1'b0;
    @(negedge clk);
    chk("R10 irq_rx gated by enable", 32'(irq_rx), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    int moved = 0;
    rst_n = 1'b0;
    cfg_prescale = '0; cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_lsb_first = 1'b0;
    cfg_frame_len = 5'd8; cfg_sw_cs = 1'b0; cfg_sw_sel = 1'b0;
    cfg_tx_ie = 1'b0; cfg_rx_ie = 1'b0;
    tx_wr = 1'b0; rx_rd = 1'b0; tx_data = '0; loopback = 1'b1;
    slave_prep(16'h0000, 8, 1'b0);
    repeat (3) @(negedge clk);
    chk("R1 cs_n in reset", 32'(cs_n), 32'd1);
    chk("R1 sclk in reset", 32'(sclk), 32'd0);
    chk("R1 busy in reset", 32'(busy), 32'd0);
    chk("R1 tx_room in reset", 32'(tx_room), 32'd1);
    chk("R1 rx_avail in reset", 32'(rx_avail), 32'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (busy || sclk) moved++;
    end
    chk("R9 idle with empty transmit queue", 32'(moved), 32'd0);
    chk("R1 cs_n after reset", 32'(cs_n), 32'd1);
    cfg_tx_ie = 1'b1;
    @(negedge clk);
    chk("R10 irq_tx with room", 32'(irq_tx), 32'd1);
    cfg_tx_ie = 1'b0;
    @(negedge clk);
    chk("R10 irq_tx gated by enable", 32'(irq_tx), 32'd0);

    t_frame(1'b0, 1'b0, 1'b0, 8,  0, 16'h00A5, 16'h003C);
    t_frame(1'b0, 1'b1, 1'b1, 16, 1, 16'h1234, 16'hBEEF);
    t_frame(1'b1, 1'b0, 1'b0, 4,  0, 16'hFFF9, 16'h0006);
    t_frame(1'b1, 1'b1, 1'b1, 13, 2, 16'hE5A1, 16'h0B3D);
    t_frame(1'b1, 1'b1, 1'b0, 5,  3, 16'h0013, 16'h000A);
    t_timing(0, 4);
    t_timing(3, 6);
    t_sw_select();
    t_gating_order();

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule